// File: doc/BRIEF.md
# Shortest-Form Instruction Byte Encoder

This block turns one decoded instruction description for a 16-bit two-address machine into its machine-code bytes. It supports three operation classes: a single-operand increment on a register or memory location, a subtract with an immediate source, and a subtract between a register and a register-or-memory operand. For each description it builds the opcode byte and the addressing byte. It picks the shortest displacement form that holds the offset and the shortest immediate form that holds the constant. It then sends between two and six bytes out, one per handshake.

A producer presents a description with `inValid`. The description is taken in a cycle where `inReady` is high. Bytes then leave on a valid/ready stream. A byte stays stable while the consumer holds `outReady` low, and `outLast` marks the final byte of the instruction. Multi-byte displacements and immediates are sent low byte first, and the displacement comes before the immediate.

Top module: `instEncoder`

## Requirements
- R1: After reset `outValid` is low and `inReady` is high.
- R2: A description is accepted only in a cycle where `inReady` is high. `inReady` stays low while bytes are pending. The first byte is valid in the cycle after acceptance. While `outValid` is high and `outReady` is low, `outByte` and `outLast` hold their values.
- R3: The first byte is selected by the class code. For class 0 (increment) it is 8'hFE|w and the middle field of byte two is 000. For class 1 (subtract immediate) it is 8'h80|(s<<1)|w and the middle field is 101. For class 2 (subtract register form) it is 8'h28|(d<<1)|w. Class code 3 behaves exactly like class 2.
- R4: Byte two packs mod in bits 7:6, the middle field in bits 5:3 and r/m in bits 2:0. A register operand (`memOp`=0) gives mod=11 with r/m equal to `rmReg`, and no displacement follows.
- R5: A based memory operand puts `baseMode` in r/m. If the displacement is zero and `baseMode` is not 6, the encoder uses mod=00 and sends no displacement. If the displacement lies in -128..+127, it uses mod=01 and sends one byte. Otherwise it uses mod=10 and sends two bytes, low byte first.
- R6: `baseMode` 6 with a zero displacement uses mod=01 followed by one byte 8'h00.
- R7: A direct operand (`memOp`=1, `direct`=1) uses mod=00 and r/m=110. It is followed by both bytes of `disp` as the address, low byte first, whatever its value.
- R8: In class 1, w=0 sends the low immediate byte with s=0. When w=1 and `imm` lies in -128..+127, the encoder sets s=1 and sends one byte. Otherwise it sets s=0 and sends two bytes, low byte first. The immediate follows any displacement.
- R9: In classes 2 and 3, the middle field is `regNum`. d is 1 only when `memOp`=1 and `memIsSrc`=1. A register-to-register operation uses d=0 and ignores `memIsSrc`, and its r/m field holds `rmReg` as the destination.
- R10: `outLast` is high on the final byte only. The instruction length is 2 plus the displacement bytes plus the immediate bytes, so at most 6. `outValid` is low in the cycle after the final byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Description present |
| inReady | output | 1 | Encoder idle, takes description |
| opClass | input | 2 | 0 increment, 1 subtract immediate, 2/3 subtract register form |
| wide | input | 1 | w bit: 1 selects 16-bit operand |
| memOp | input | 1 | The r/m operand is in memory |
| memIsSrc | input | 1 | Register form: memory operand is the source |
| direct | input | 1 | Memory operand is a direct address |
| baseMode | input | 3 | Base/index combination placed in r/m |
| rmReg | input | 3 | Register number for a register r/m operand |
| regNum | input | 3 | Register number for the middle field (register form) |
| disp | input | 16 | Displacement or direct address |
| imm | input | 16 | Immediate source value |
| outValid | output | 1 | Byte present |
| outReady | input | 1 | Consumer takes byte |
| outByte | output | 8 | Encoded byte |
| outLast | output | 1 | Final byte of the instruction |

## Verification
The first byte of an instruction is due in the cycle after the acceptance edge. Each later byte is due in the cycle after the previous byte's handshake. `inReady` and a low `outValid` are due in the cycle after the final handshake. The bench drives inputs and samples on the falling edge, so each result is read half a cycle after the rising edge that produced it. It checks the acceptance cycle, each byte taken, and the idle cycle after the last byte. While random backpressure holds `outReady` low, it compares each byte against the value shown in the previous stalled cycle.

// File: rtl/instEncPkg.sv
package instEncPkg;
  localparam int REG_W   = 3;
  localparam int WORD_W  = 16;
  localparam int MAX_LEN = 6;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int PTR_W   = $clog2(MAX_LEN);

  typedef enum logic [1:0] {
    CLS_INC     = 2'd0,
    CLS_SUBIMM  = 2'd1,
    CLS_SUBRM   = 2'd2,
    CLS_SUBRM_B = 2'd3
  } opClass_e;

  typedef struct packed {
    opClass_e          cls;
    logic              wide;
    logic              memOp;
    logic              memIsSrc;
    logic              direct;
    logic [REG_W-1:0]  baseMode;
    logic [REG_W-1:0]  rmReg;
    logic [REG_W-1:0]  regNum;
    logic [WORD_W-1:0] disp;
    logic [WORD_W-1:0] imm;
  } instDesc_t;

  typedef struct packed {
    logic load;
    logic advance;
  } encStrobe_t;
endpackage

// File: rtl/instEncForm.sv
module instEncForm
  import instEncPkg::*;
(
  input  instDesc_t                 desc,
  output logic [MAX_LEN-1:0][7:0]   bytes,
  output logic [LEN_W-1:0]          len
);
  localparam int TAIL_BYTES = MAX_LEN - 2;
  localparam logic [REG_W-1:0] BP_ONLY = 3'd6;

  function automatic logic fitsByte(input logic [WORD_W-1:0] v);
    return v[WORD_W-1:7] == {(WORD_W-7){v[7]}};
  endfunction

  logic [1:0]       modSel;
  logic [REG_W-1:0] rmSel;
  logic [REG_W-1:0] midSel;
  logic [1:0]       dispLen;
  logic [1:0]       immLen;
  logic             sBit;
  logic             dBit;
  logic [WORD_W-1:0] dispMask;
  logic [WORD_W-1:0] immMask;
  logic [TAIL_BYTES*8-1:0] tail;
  logic [7:0]       opByte;
  logic             isRegForm;

  assign isRegForm = (desc.cls == CLS_SUBRM) || (desc.cls == CLS_SUBRM_B);

  // addressing byte fields and displacement length
  always_comb begin
    modSel  = 2'b11;
    rmSel   = desc.rmReg;
    dispLen = 2'd0;
    if (desc.memOp) begin
      if (desc.direct) begin
        modSel  = 2'b00;
        rmSel   = BP_ONLY;
        dispLen = 2'd2;
      end else begin
        rmSel = desc.baseMode;
        if (desc.disp == '0 && desc.baseMode != BP_ONLY) begin
          modSel  = 2'b00;
          dispLen = 2'd0;
        end else if (fitsByte(desc.disp)) begin
          modSel  = 2'b01;
          dispLen = 2'd1;
        end else begin
          modSel  = 2'b10;
          dispLen = 2'd2;
        end
      end
    end
  end

  // immediate length, sign-extend and direction bits, middle field
  always_comb begin
    immLen = 2'd0;
    sBit   = 1'b0;
    dBit   = 1'b0;
    midSel = '0;
    case (desc.cls)
      CLS_INC: midSel = 3'b000;
      CLS_SUBIMM: begin
        midSel = 3'b101;
        if (!desc.wide) begin
          immLen = 2'd1;
        end else if (fitsByte(desc.imm)) begin
          immLen = 2'd1;
          sBit   = 1'b1;
        end else begin
          immLen = 2'd2;
        end
      end
      default: begin
        midSel = desc.regNum;
        dBit   = desc.memOp & desc.memIsSrc;
      end
    endcase
  end

  always_comb begin
    case (desc.cls)
      CLS_INC:    opByte = {7'b1111111, desc.wide};
      CLS_SUBIMM: opByte = {6'b100000, sBit, desc.wide};
      default:    opByte = {6'b001010, dBit, desc.wide};
    endcase
  end

  // pack displacement then immediate, low bytes first
  always_comb begin
    dispMask = (dispLen == 2'd2) ? desc.disp :
               (dispLen == 2'd1) ? {8'h00, desc.disp[7:0]} : '0;
    immMask  = (immLen == 2'd2) ? desc.imm :
               (immLen == 2'd1) ? {8'h00, desc.imm[7:0]} : '0;
    tail = ({{(TAIL_BYTES*8-WORD_W){1'b0}}, immMask} << {dispLen, 3'b000})
         | {{(TAIL_BYTES*8-WORD_W){1'b0}}, dispMask};
  end

  always_comb begin
    bytes[0] = opByte;
    bytes[1] = {modSel, midSel, rmSel};
  end

  for (genvar g = 0; g < TAIL_BYTES; g++) begin : gTail
    assign bytes[g+2] = tail[g*8 +: 8];
  end

  assign len = LEN_W'(2) + LEN_W'(dispLen) + LEN_W'(immLen);

  logic unusedForm;
  assign unusedForm = isRegForm;
endmodule

// File: rtl/instEncPath.sv
module instEncPath
  import instEncPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  encStrobe_t strobe,
  input  instDesc_t  descIn,
  output logic [7:0] byteOut,
  output logic       atLast
);
  instDesc_t               descQ;
  logic [PTR_W-1:0]        ptr;
  logic [MAX_LEN-1:0][7:0] formBytes;
  logic [LEN_W-1:0]        formLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descQ <= '0;
      ptr   <= '0;
    end else if (strobe.load) begin
      descQ <= descIn;
      ptr   <= '0;
    end else if (strobe.advance) begin
      ptr <= ptr + 1'b1;
    end
  end

  instEncForm uForm (
    .desc  (descQ),
    .bytes (formBytes),
    .len   (formLen)
  );

  assign byteOut = formBytes[ptr];
  assign atLast  = (LEN_W'(ptr) == formLen - LEN_W'(1));
endmodule

// File: rtl/instEncCtrl.sv
module instEncCtrl
  import instEncPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       atLast,
  output logic       inReady,
  output logic       outValid,
  output encStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_EMIT} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (inValid) stateNext = ST_EMIT;
      ST_EMIT: if (outReady && atLast) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign inReady        = (state == ST_IDLE);
  assign outValid       = (state == ST_EMIT);
  assign strobe.load    = inReady && inValid;
  assign strobe.advance = outValid && outReady && !atLast;
endmodule

// File: rtl/instEncoder.sv
module instEncoder
  import instEncPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [1:0]  opClass,
  input  logic        wide,
  input  logic        memOp,
  input  logic        memIsSrc,
  input  logic        direct,
  input  logic [2:0]  baseMode,
  input  logic [2:0]  rmReg,
  input  logic [2:0]  regNum,
  input  logic [15:0] disp,
  input  logic [15:0] imm,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outByte,
  output logic        outLast
);
  instDesc_t  descIn;
  encStrobe_t strobe;
  logic       atLast;

  always_comb begin
    descIn.cls      = opClass_e'(opClass);
    descIn.wide     = wide;
    descIn.memOp    = memOp;
    descIn.memIsSrc = memIsSrc;
    descIn.direct   = direct;
    descIn.baseMode = baseMode;
    descIn.rmReg    = rmReg;
    descIn.regNum   = regNum;
    descIn.disp     = disp;
    descIn.imm      = imm;
  end

  instEncCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .atLast   (atLast),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  instEncPath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .descIn  (descIn),
    .byteOut (outByte),
    .atLast  (atLast)
  );

  assign outLast = outValid && atLast;
endmodule

// File: rtl/instEncChecker.sv
module instEncChecker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outByte,
  input logic       outLast
);
  logic       firstPending;
  logic [2:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPending <= 1'b0;
      beatCnt      <= '0;
    end else if (inValid && inReady) begin
      firstPending <= 1'b1;
      beatCnt      <= '0;
    end else if (outValid && outReady) begin
      firstPending <= 1'b0;
      beatCnt      <= beatCnt + 1'b1;
    end
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  a_r2_accept_next: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte) && $stable(outLast));

  a_r3_opcode: assert property (@(posedge clk) disable iff (!rstN)
    outValid && firstPending |->
      (outByte[7:1] == 7'b1111111) || (outByte[7:2] == 6'b100000) ||
      (outByte[7:2] == 6'b001010));

  a_r10_not_first: assert property (@(posedge clk) disable iff (!rstN)
    outValid && firstPending |-> !outLast);

  a_r10_max_len: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> beatCnt <= 3'd5);

  a_r10_idle_after: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid && inReady);
endmodule

bind instEncoder instEncChecker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outByte  (outByte),
  .outLast  (outLast)
);

// File: tb/instEncoder_test.sv
module instEncoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  opClass = '0;
  logic        wide = 1'b0;
  logic        memOp = 1'b0;
  logic        memIsSrc = 1'b0;
  logic        direct = 1'b0;
  logic [2:0]  baseMode = '0;
  logic [2:0]  rmReg = '0;
  logic [2:0]  regNum = '0;
  logic [15:0] disp = '0;
  logic [15:0] imm = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outByte;
  logic        outLast;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  instEncoder uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit fits8(input logic [15:0] v);
    return ($signed(v) >= -128) && ($signed(v) <= 127);
  endfunction

  function automatic int model(input logic [1:0] c, input logic w, m, s, dr,
                               input logic [2:0] bm, rr, rn,
                               input logic [15:0] dv, iv,
                               output logic [5:0][7:0] eb);
    logic [1:0] md; logic [2:0] rm, mid; int nd, ni, k; logic sb, db;
    logic [7:0] op;
    eb = '0; nd = 0; ni = 0; sb = 0; db = 0;
    if (!m) begin md = 2'b11; rm = rr; end
    else if (dr) begin md = 2'b00; rm = 3'd6; nd = 2; end
    else begin
      rm = bm;
      if (dv == 16'h0 && bm != 3'd6) md = 2'b00;
      else if (fits8(dv)) begin md = 2'b01; nd = 1; end
      else begin md = 2'b10; nd = 2; end
    end
    if (c == 2'd0) begin mid = 3'b000; op = {7'h7F, w}; end
    else if (c == 2'd1) begin
      mid = 3'b101;
      if (!w) ni = 1;
      else if (fits8(iv)) begin ni = 1; sb = 1; end
      else ni = 2;
      op = {6'b100000, sb, w};
    end else begin
      mid = rn; db = m & s;
      op = {6'b001010, db, w};
    end
    eb[0] = op;
    eb[1] = {md, mid, rm};
    k = 2;
    if (nd >= 1) begin eb[k] = dv[7:0]; k++; end
    if (nd == 2) begin eb[k] = dv[15:8]; k++; end
    if (ni >= 1) begin eb[k] = iv[7:0]; k++; end
    if (ni == 2) begin eb[k] = iv[15:8]; k++; end
    return k;
  endfunction

  task automatic runInst(input logic [1:0] c, input logic w, m, s, dr,
                         input logic [2:0] bm, rr, rn,
                         input logic [15:0] dv, iv, input string tag);
    logic [5:0][7:0] eb; int el; int got; logic [7:0] prevB; bit prevHold;
    el = model(c, w, m, s, dr, bm, rr, rn, dv, iv, eb);
    opClass = c; wide = w; memOp = m; memIsSrc = s; direct = dr;
    baseMode = bm; rmReg = rr; regNum = rn; disp = dv; imm = iv;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid && !inReady, "R2", "valid after accept", {outValid, inReady}, 2'b10);
    got = 0; prevHold = 0; prevB = '0;
    while (got < el) begin
      outReady = ($urandom % 4) != 0;
      if (outValid) begin
        if (prevHold) chk(outByte == prevB, "R2", "hold byte", outByte, prevB);
        if (outReady) begin
          chk(outByte == eb[got], tag, $sformatf("byte %0d", got), outByte, eb[got]);
          chk(outLast == (got == el - 1), "R10", $sformatf("last at %0d", got),
              outLast, (got == el - 1));
          got++; prevHold = 0;
        end else begin
          prevHold = 1; prevB = outByte;
        end
      end else begin
        chk(1'b0, "R2", "byte missing", 0, 1);
        got = el;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(!outValid && inReady, "R10", "idle after last", {outValid, inReady}, 2'b01);
  endtask

  function automatic logic [15:0] pickWord();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'(($urandom % 256) - 128);
      2: return 16'h007F + 16'($urandom % 3);
      3: return 16'hFF80 - 16'($urandom % 3);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && inReady, "R1", "reset state", {outValid, inReady}, 2'b01);

    runInst(2'd0, 0, 0, 0, 0, 3'd0, 3'd6, 3'd0, 16'h0, 16'h0, "R4");
    runInst(2'd0, 1, 0, 0, 0, 3'd0, 3'd7, 3'd0, 16'h0, 16'h0, "R3");
    runInst(2'd0, 0, 1, 0, 0, 3'd4, 3'd0, 3'd0, 16'hFFFC, 16'h0, "R5");
    runInst(2'd0, 0, 1, 0, 0, 3'd4, 3'd0, 3'd0, 16'h0080, 16'h0, "R5");
    runInst(2'd0, 1, 1, 0, 0, 3'd4, 3'd0, 3'd0, 16'h007F, 16'h0, "R5");
    runInst(2'd0, 1, 1, 0, 0, 3'd5, 3'd0, 3'd0, 16'hFF80, 16'h0, "R5");
    runInst(2'd0, 1, 1, 0, 0, 3'd5, 3'd0, 3'd0, 16'hFF7F, 16'h0, "R5");
    runInst(2'd0, 0, 1, 0, 0, 3'd7, 3'd0, 3'd0, 16'h0, 16'h0, "R5");
    runInst(2'd0, 0, 1, 0, 0, 3'd6, 3'd0, 3'd0, 16'h0, 16'h0, "R6");
    runInst(2'd1, 1, 1, 0, 1, 3'd0, 3'd0, 3'd0, 16'h0200, 16'h0031, "R7");
    runInst(2'd0, 1, 1, 0, 1, 3'd0, 3'd0, 3'd0, 16'h0000, 16'h0, "R7");
    runInst(2'd1, 1, 1, 0, 0, 3'd7, 3'd0, 3'd0, 16'd500, 16'hF0F0, "R8");
    runInst(2'd1, 0, 0, 0, 0, 3'd0, 3'd3, 3'd0, 16'h0, 16'h1285, "R8");
    runInst(2'd1, 1, 0, 0, 0, 3'd0, 3'd1, 3'd0, 16'h0, 16'h0080, "R8");
    runInst(2'd1, 1, 0, 0, 0, 3'd0, 3'd1, 3'd0, 16'h0, 16'hFF80, "R8");
    runInst(2'd2, 1, 1, 0, 1, 3'd0, 3'd0, 3'd6, 16'h0020, 16'h0, "R9");
    runInst(2'd2, 1, 0, 0, 0, 3'd0, 3'd3, 3'd1, 16'h0, 16'h0, "R9");
    runInst(2'd2, 1, 0, 1, 0, 3'd0, 3'd3, 3'd1, 16'h0, 16'h0, "R9");
    runInst(2'd2, 1, 1, 1, 0, 3'd7, 3'd0, 3'd6, 16'h0, 16'h0, "R9");
    runInst(2'd3, 0, 1, 1, 0, 3'd2, 3'd0, 3'd5, 16'h1234, 16'h0, "R3");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] c; logic m;
      c = 2'($urandom % 4);
      m = 1'($urandom);
      runInst(c, 1'($urandom), m, 1'($urandom), m & (($urandom % 4) == 0),
              3'($urandom), 3'($urandom), 3'($urandom), pickWord(), pickWord(),
              "R3 R5 R8");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule